// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block is the digital half of a dual-slope integrating converter. A start request closes the input switch so the unknown voltage charges an external integrator. Once the zero-detector comparator reports that the integrator has left zero, a four-digit BCD counter runs for exactly one full turn of 10000 clocks. The rollover from all nines to all zeros swaps the input switch for the negative-reference switch. The same counter, now starting again from zero, then times the run-down until the comparator reports the return to zero.

The count at that moment is proportional to the input voltage. It does not depend on the clock period, because both phases are timed by the same clock. The count is stored as a BCD word and announced with a one-clock valid pulse. If the run-down does not finish within 10000 clocks, the conversion ends with an overrange flag. The comparator is asynchronous to the block and passes through a two-flop synchroniser.

The result leaves the block as a strobe, not a stream. There is no ready input and no back-pressure. A consumer must take the word on the valid pulse, or read it later from the held register, which keeps its value until the next conversion completes.

Top module: `dsadc_seq`

## Requirements
- R1: After reset both switch outputs, busy, result_valid and over_range are 0, and bcd_result is all zeros.
- R2: A start pulse while idle closes the input switch and raises busy on the next clock, with the reference switch open.
- R3: The comparator passes two synchroniser flops. The integrate count begins on the first clock the synchronised comparator reads 1, and lasts exactly 10000 clocks. If the comparator is raised A clocks after the input switch is first seen closed, the input switch stays closed for A+10003 clocks in total.
- R4: At the counter rollover, the input switch opens on the same clock edge that the reference switch closes, and the two switch outputs are never high together.
- R5: The de-integrate count is the number of reference-phase clocks before the synchronised comparator first reads 0. If the comparator falls D clocks after the reference switch is first seen closed, the result is D+2. bcd_result carries one decimal digit per nibble, with the least significant digit in bits 3:0.
- R6: result_valid is a single-clock pulse. It is raised on the edge where busy falls and the reference switch opens, and bcd_result keeps its value until the next completion.
- R7: If the synchronised comparator still reads 1 when the de-integrate count is at 9999, the conversion ends with over_range=1, a result of 9999, a valid pulse and both switches open. A zero reading in that same clock gives a normal result of 9999 with over_range=0.
- R8: A start pulse while busy is ignored, and the conversion in progress keeps its timing.
- R9: Every nibble of bcd_result is a decimal digit in the range 0 to 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_start | input | 1 | Start request, acted on only when idle |
| zero_cmp | input | 1 | Asynchronous zero-detector output, 1 while the integrator is away from zero |
| sel_input | output | 1 | Connects the unknown input to the integrator |
| sel_ref | output | 1 | Connects the negative reference to the integrator |
| bcd_result | output | 4*DIGITS | Held de-integrate count, in BCD |
| result_valid | output | 1 | One-clock strobe when a conversion ends |
| over_range | output | 1 | The last conversion ran out of de-integrate count |
| busy | output | 1 | High from start until the end of the conversion |

## Verification
Two events can land on the same clock. One is the zero crossing reported by the synchronised comparator. The other is the de-integrate counter reaching its limit of 9999. The bench provokes the collision by dropping the comparator exactly 9997 clocks into the reference phase, which must give a normal result of 9999. A drop one clock later must give the overrange ending instead. Random run-up and run-down lengths fill the space between these two cases, and each result is compared against D+2 computed in the bench.

// File: rtl/dsadc_pkg.sv
package dsadc_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_ARM   = 2'd1,
    PH_INTEG = 2'd2,
    PH_DEINT = 2'd3
  } phase_t;
endpackage

// File: rtl/dsadc_sync.sv
module dsadc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d_async};
  end

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/dsadc_bcd_counter.sv
module dsadc_bcd_counter #(
  parameter int DIGITS = 4,
  localparam int W = 4 * DIGITS
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  output logic [W-1:0] count,
  output logic         at_max
);
  logic [DIGITS:0]   carry;
  logic [DIGITS-1:0] nine;

  assign carry[0] = en;

  for (genvar d = 0; d < DIGITS; d++) begin : g_digit
    logic [3:0] dig;
    assign nine[d]      = (dig == 4'd9);
    assign carry[d+1]   = carry[d] & nine[d];
    assign count[4*d+:4] = dig;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        dig <= 4'd0;
      else if (clr)      dig <= 4'd0;
      else if (carry[d]) dig <= nine[d] ? 4'd0 : dig + 4'd1;
    end
  end

  assign at_max = &nine;
endmodule

// File: rtl/dsadc_ctrl.sv
module dsadc_ctrl
  import dsadc_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         cmp_s,
  input  logic         cnt_max,
  input  logic [W-1:0] cnt_val,
  output logic         cnt_clr,
  output logic         cnt_en,
  output logic         sel_input,
  output logic         sel_ref,
  output logic         busy,
  output logic [W-1:0] result,
  output logic         valid,
  output logic         overrange
);
  phase_t phase, phase_nx;
  logic   finish, finish_ovr;

  always_comb begin
    phase_nx   = phase;
    cnt_clr    = 1'b0;
    cnt_en     = 1'b0;
    finish     = 1'b0;
    finish_ovr = 1'b0;
    unique case (phase)
      PH_IDLE: if (start) begin
        cnt_clr  = 1'b1;
        phase_nx = PH_ARM;
      end
      PH_ARM: if (cmp_s) phase_nx = PH_INTEG;
      PH_INTEG: begin
        cnt_en = 1'b1;
        if (cnt_max) phase_nx = PH_DEINT;
      end
      PH_DEINT: begin
        if (!cmp_s) begin
          finish   = 1'b1;
          phase_nx = PH_IDLE;
        end else if (cnt_max) begin
          finish     = 1'b1;
          finish_ovr = 1'b1;
          phase_nx   = PH_IDLE;
        end else begin
          cnt_en = 1'b1;
        end
      end
      default: phase_nx = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      result    <= '0;
      valid     <= 1'b0;
      overrange <= 1'b0;
    end else begin
      phase <= phase_nx;
      valid <= finish;
      if (finish) begin
        result    <= cnt_val;
        overrange <= finish_ovr;
      end
    end
  end

  assign sel_input = (phase == PH_ARM) || (phase == PH_INTEG);
  assign sel_ref   = (phase == PH_DEINT);
  assign busy      = (phase != PH_IDLE);
endmodule

// File: rtl/dsadc_seq.sv
module dsadc_seq #(
  parameter int DIGITS      = 4,
  parameter int SYNC_STAGES = 2,
  localparam int W = 4 * DIGITS
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         conv_start,
  input  logic         zero_cmp,
  output logic         sel_input,
  output logic         sel_ref,
  output logic [W-1:0] bcd_result,
  output logic         result_valid,
  output logic         over_range,
  output logic         busy
);
  logic         cmp_s;
  logic         cnt_clr, cnt_en, cnt_max;
  logic [W-1:0] cnt_val;

  dsadc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(zero_cmp), .q_sync(cmp_s)
  );

  dsadc_bcd_counter #(.DIGITS(DIGITS)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .en(cnt_en),
    .count(cnt_val), .at_max(cnt_max)
  );

  dsadc_ctrl #(.W(W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(conv_start), .cmp_s(cmp_s),
    .cnt_max(cnt_max), .cnt_val(cnt_val),
    .cnt_clr(cnt_clr), .cnt_en(cnt_en),
    .sel_input(sel_input), .sel_ref(sel_ref), .busy(busy),
    .result(bcd_result), .valid(result_valid), .overrange(over_range)
  );
endmodule

// File: rtl/dsadc_seq_chk.sv
module dsadc_seq_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         conv_start,
  input logic         sel_input,
  input logic         sel_ref,
  input logic [W-1:0] bcd_result,
  input logic         result_valid,
  input logic         over_range,
  input logic         busy
);
  localparam int ND = W / 4;

  a_r4_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(sel_input && sel_ref));

  a_r1_idle_open: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!sel_input && !sel_ref));

  a_r2_start_arms: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_start && !busy) |=> (busy && sel_input && !sel_ref));

  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |=> !result_valid);

  a_r6_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |-> (!busy && !sel_ref));

  a_r6_result_held: assert property (@(posedge clk) disable iff (!rst_n)
    !result_valid |-> $stable(bcd_result));

  a_r7_ovr_full: assert property (@(posedge clk) disable iff (!rst_n)
    over_range |-> (bcd_result == {ND{4'd9}}));

  a_r4_handover: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sel_ref) |-> $fell(sel_input));

  for (genvar d = 0; d < ND; d++) begin : g_dig
    a_r9_decimal: assert property (@(posedge clk) disable iff (!rst_n)
      bcd_result[4*d+:4] <= 4'd9);
  end
endmodule

bind dsadc_seq dsadc_seq_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .conv_start(conv_start),
  .sel_input(sel_input), .sel_ref(sel_ref), .bcd_result(bcd_result),
  .result_valid(result_valid), .over_range(over_range), .busy(busy)
);

// File: tb/dsadc_seq_tb.sv
`timescale 1ns/1ps
module dsadc_seq_tb;
  localparam int DIGITS = 4;
  localparam int W      = 4 * DIGITS;
  localparam int FULL   = 10000;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         conv_start = 1'b0;
  logic         zero_cmp = 1'b0;
  logic         sel_input, sel_ref, result_valid, over_range, busy;
  logic [W-1:0] bcd_result;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  dsadc_seq #(.DIGITS(DIGITS)) u_dut (
    .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .zero_cmp(zero_cmp),
    .sel_input(sel_input), .sel_ref(sel_ref), .bcd_result(bcd_result),
    .result_valid(result_valid), .over_range(over_range), .busy(busy)
  );

  function automatic logic [W-1:0] to_bcd(int v);
    logic [W-1:0] r = '0;
    for (int d = 0; d < DIGITS; d++) begin
      r[4*d+:4] = 4'(v % 10);
      v = v / 10;
    end
    return r;
  endfunction

  function automatic int exp_count(int dly);
    return (dly + 2 <= FULL - 1) ? dly + 2 : FULL - 1;
  endfunction

  function automatic bit exp_ovr(int dly);
    return (dly + 2 > FULL - 1);
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic convert(int a_dly, int d_dly, bit mid_start);
    int in_cycles = 0;
    int k = 0;
    int j = 0;
    logic [W-1:0] held;
    @(negedge clk) conv_start = 1'b1;
    @(negedge clk) conv_start = 1'b0;
    check(busy && sel_input && !sel_ref, "R2 armed", {busy, sel_input, sel_ref}, 3'b110);
    forever begin
      if (k == a_dly) zero_cmp = 1'b1;
      conv_start = (mid_start && k == a_dly + 500);
      if (sel_input && sel_ref) check(1'b0, "R4 overlap", 1, 0);
      if (sel_ref) break;
      if (sel_input) in_cycles++;
      k++;
      @(negedge clk);
    end
    conv_start = 1'b0;
    check(in_cycles == a_dly + 10003, "R3 integrate length", in_cycles, a_dly + 10003);
    check(!sel_input, "R4 input opened at handover", sel_input, 0);
    forever begin
      if (result_valid) break;
      if (j == d_dly) zero_cmp = 1'b0;
      if (sel_input) check(1'b0, "R4 input during deint", 1, 0);
      j++;
      @(negedge clk);
    end
    check(j == (exp_ovr(d_dly) ? FULL : d_dly + 3), "R5 valid timing", j,
          exp_ovr(d_dly) ? FULL : d_dly + 3);
    check(bcd_result == to_bcd(exp_count(d_dly)),
          exp_ovr(d_dly) ? "R7 overrange result" : "R5 result",
          bcd_result, to_bcd(exp_count(d_dly)));
    check(over_range == exp_ovr(d_dly), "R7 flag", over_range, exp_ovr(d_dly));
    check(!busy && !sel_ref && !sel_input, "R6 ends with switches open",
          {busy, sel_ref, sel_input}, 0);
    held = bcd_result;
    zero_cmp = 1'b0;
    @(negedge clk);
    check(!result_valid, "R6 one-clock valid", result_valid, 0);
    repeat (4) @(negedge clk);
    check(bcd_result == held, "R6 result held", bcd_result, held);
    check(!busy, "R8 no restart from ignored start", busy, 0);
  endtask

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    check(!sel_input && !sel_ref && !busy && !result_valid && !over_range && bcd_result == '0,
          "R1 reset state", {sel_input, sel_ref, busy, result_valid, over_range}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!busy && !sel_input, "R1 idle after reset", busy, 0);
    convert(0, 0, 1'b0);
    convert(7, 9997, 1'b0);
    convert(3, 9998, 1'b1);
    for (int i = 0; i < 5; i++) begin
      convert(int'($urandom_range(0, 20)), int'($urandom_range(0, 3000)), i[0]);
    end
    check(bcd_result[3:0] <= 4'd9, "R9 decimal digit", bcd_result[3:0], 9);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule